// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block takes one read or write request at a time from an internal requester and plays it out as a timed strobe sequence on an external asynchronous memory bus. Every access walks through a setup phase, a strobe phase and a hold phase, then a turnaround gap before the block returns to idle. The length of each phase comes from per-chip-select configuration inputs. Reads and writes have separate setup, strobe and hold counts, and one turnaround count is shared by both. Each count is programmed as the wanted number of clock cycles minus one.

Each chip-select space has its own mode bit and width bit. In normal mode the chip select frames the whole setup-strobe-hold window. In select-strobe mode the chip select behaves like a strobe and is low only in the strobe phase. The width bit picks an 8-bit or a 16-bit device, and this choice sets how the low address bits map onto the two bank-address pins and onto the data bus. The whole configuration for an access is captured when the request is accepted.

The state machine has five states. IDLE moves to SETUP when a request is accepted. SETUP, STROBE and HOLD each move to the next phase when their counter reaches zero. HOLD moves to TURN. TURN moves back to IDLE when its counter reaches zero, and it raises the done pulse in that last cycle. In every other case a state stays where it is and counts down.

Top module: `async_mem_seq`

## Requirements
- R1: An accepted access spends exactly F+1 cycles in each phase, where F is the field for that phase. The phases run in the order setup, strobe, hold, turnaround. Reads use the read setup, strobe and hold fields, writes use the write fields, and both use the turnaround field. Each field of chip select i sits at bits [i*W +: W] of its configuration vector, where W is the field width.
- R2: After reset the block is idle: `req_ready`=1, all `mem_cs_n`=1, `mem_oe_n`=1, `mem_we_n`=1, `mem_rw`=1, `mem_doe`=0, `mem_a`=0, `mem_ba`=0, `rd_data`=0. A request is taken only in a cycle where `req_ready` is 1. `req_ready` is 0 from the first setup cycle through the last turnaround cycle, and `req_valid` has no effect in those cycles.
- R3: When `cfg_ss[cs]`=0 (normal mode), `mem_cs_n[cs]` is 0 in every setup, strobe and hold cycle and 1 otherwise. All other chip selects stay at 1.
- R4: When `cfg_ss[cs]`=1 (select-strobe mode), `mem_cs_n[cs]` is 0 only in strobe cycles.
- R5: `mem_oe_n` is 0 exactly in the strobe cycles of a read. `mem_we_n` is 0 exactly in the strobe cycles of a write.
- R6: `mem_rw` is 0 in every setup, strobe and hold cycle of a write and 1 in all other cycles.
- R7: `mem_a` equals `req_addr[ADDR_W-1:2]`. With `cfg_wide[cs]`=0 (8-bit device), `mem_ba` equals `req_addr[1:0]`. With `cfg_wide[cs]`=1 (16-bit device), `mem_ba` equals {`req_addr[1]`, 0}. These values hold from the first setup cycle until the next request is accepted.
- R8: `mem_doe` is 1 exactly in the setup, strobe and hold cycles of a write. In those cycles `mem_dout` is the write data for a 16-bit device, or {8'h00, write data[7:0]} for an 8-bit device.
- R9: On a read, `mem_din` is sampled on the last strobe cycle. From the next cycle on, `rd_data` shows `mem_din` for a 16-bit device or {8'h00, `mem_din[7:0]`} for an 8-bit device, and it keeps that value until the next read captures.
- R10: `done` is 1 for exactly one cycle, the last turnaround cycle, and the block is idle in the cycle after it.
- R11: The chip select, direction, address, write data, mode, width and timing fields are all captured when the request is accepted. Changing the configuration inputs during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | CS_W | Target chip-select space |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle, request will be taken |
| cfg_ss | input | NCS | Select-strobe mode per space |
| cfg_wide | input | NCS | 1 for 16-bit device per space |
| cfg_rd_setup | input | NCS*SETUP_W | Read setup cycles minus one |
| cfg_rd_strobe | input | NCS*STROBE_W | Read strobe cycles minus one |
| cfg_rd_hold | input | NCS*HOLD_W | Read hold cycles minus one |
| cfg_wr_setup | input | NCS*SETUP_W | Write setup cycles minus one |
| cfg_wr_strobe | input | NCS*STROBE_W | Write strobe cycles minus one |
| cfg_wr_hold | input | NCS*HOLD_W | Write hold cycles minus one |
| cfg_turn | input | NCS*TURN_W | Turnaround cycles minus one |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_rw | output | 1 | Direction, 0 during writes |
| mem_a | output | ADDR_W-2 | External address |
| mem_ba | output | 2 | Bank-address pins |
| mem_dout | output | 16 | Write data to pins |
| mem_doe | output | 1 | Data pin output enable |
| mem_din | input | 16 | Data from pins |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | Access complete pulse |

## Verification
The bench targets the zero-valued fields, where each phase lasts a single cycle. A design that treats a field value as the cycle count instead of the count minus one would skip that phase or stay one cycle short in it. The bench also runs the largest strobe and setup values, which expose a counter width that is too narrow. An 8-bit read at an address whose low bits are both 1 shows whether the bank-address pins and the upper data byte are handled correctly. A mapping mistake puts the wrong bits on `mem_ba`, and a missing zero-fill leaks `mem_din[15:8]` into `rd_data`. The bench also drives a select-strobe write while a second request and new configuration values arrive mid-access. A design that decodes the configuration live, or that accepts requests while busy, would change the chip-select shape or the address in the middle of the strobe sequence.

// File: rtl/amseq_pkg.sv
package amseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_TURN   = 3'd4
    } phase_e;

    // Zero-extend a narrow device byte onto the 16-bit internal lane
    function automatic logic [15:0] lane_fmt(input logic wide, input logic [15:0] v);
        return wide ? v : {8'h00, v[7:0]};
    endfunction

endpackage

// File: rtl/amseq_cfg_sel.sv
module amseq_cfg_sel #(
    parameter int NCS      = 4,
    parameter int CS_W     = 2,
    parameter int SETUP_W  = 4,
    parameter int STROBE_W = 6,
    parameter int HOLD_W   = 3,
    parameter int TURN_W   = 2
) (
    input  logic [CS_W-1:0]          sel,
    input  logic                     write,
    input  logic [NCS-1:0]           cfg_ss,
    input  logic [NCS-1:0]           cfg_wide,
    input  logic [NCS*SETUP_W-1:0]   cfg_rd_setup,
    input  logic [NCS*STROBE_W-1:0]  cfg_rd_strobe,
    input  logic [NCS*HOLD_W-1:0]    cfg_rd_hold,
    input  logic [NCS*SETUP_W-1:0]   cfg_wr_setup,
    input  logic [NCS*STROBE_W-1:0]  cfg_wr_strobe,
    input  logic [NCS*HOLD_W-1:0]    cfg_wr_hold,
    input  logic [NCS*TURN_W-1:0]    cfg_turn,
    output logic [SETUP_W-1:0]       setup_len,
    output logic [STROBE_W-1:0]      strobe_len,
    output logic [HOLD_W-1:0]        hold_len,
    output logic [TURN_W-1:0]        turn_len,
    output logic                     ss_mode,
    output logic                     wide
);

    logic [SETUP_W-1:0]  rs_a [NCS];
    logic [STROBE_W-1:0] rt_a [NCS];
    logic [HOLD_W-1:0]   rh_a [NCS];
    logic [SETUP_W-1:0]  ws_a [NCS];
    logic [STROBE_W-1:0] wt_a [NCS];
    logic [HOLD_W-1:0]   wh_a [NCS];
    logic [TURN_W-1:0]   ta_a [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_unpack
        assign rs_a[g] = cfg_rd_setup [g*SETUP_W  +: SETUP_W];
        assign rt_a[g] = cfg_rd_strobe[g*STROBE_W +: STROBE_W];
        assign rh_a[g] = cfg_rd_hold  [g*HOLD_W   +: HOLD_W];
        assign ws_a[g] = cfg_wr_setup [g*SETUP_W  +: SETUP_W];
        assign wt_a[g] = cfg_wr_strobe[g*STROBE_W +: STROBE_W];
        assign wh_a[g] = cfg_wr_hold  [g*HOLD_W   +: HOLD_W];
        assign ta_a[g] = cfg_turn     [g*TURN_W   +: TURN_W];
    end

    always_comb begin
        setup_len  = write ? ws_a[sel] : rs_a[sel];
        strobe_len = write ? wt_a[sel] : rt_a[sel];
        hold_len   = write ? wh_a[sel] : rh_a[sel];
        turn_len   = ta_a[sel];
        ss_mode    = cfg_ss[sel];
        wide       = cfg_wide[sel];
    end

endmodule

// File: rtl/amseq_fsm.sv
module amseq_fsm
    import amseq_pkg::*;
#(
    parameter int SETUP_W  = 4,
    parameter int STROBE_W = 6,
    parameter int HOLD_W   = 3,
    parameter int TURN_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SETUP_W-1:0]   setup_len,
    input  logic [STROBE_W-1:0]  strobe_len,
    input  logic [HOLD_W-1:0]    hold_len,
    input  logic [TURN_W-1:0]    turn_len,
    output phase_e               phase,
    output logic                 last
);

    localparam int MAX_SH = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
    localparam int MAX_TT = (STROBE_W > TURN_W) ? STROBE_W : TURN_W;
    localparam int CNT_W  = (MAX_SH > MAX_TT) ? MAX_SH : MAX_TT;

    phase_e             state, nxt_state;
    logic [CNT_W-1:0]   cnt, nxt_cnt;
    logic               cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt_state = ST_SETUP;
                    nxt_cnt   = CNT_W'(setup_len);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    nxt_state = ST_STROBE;
                    nxt_cnt   = CNT_W'(strobe_len);
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    nxt_state = ST_HOLD;
                    nxt_cnt   = CNT_W'(hold_len);
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    nxt_state = ST_TURN;
                    nxt_cnt   = CNT_W'(turn_len);
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_TURN: begin
                if (cnt_zero) begin
                    nxt_state = ST_IDLE;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            default: begin
                nxt_state = ST_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    assign phase = state;
    assign last  = cnt_zero;

endmodule

// File: rtl/amseq_pins.sv
module amseq_pins
    import amseq_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int CS_W   = 2,
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_e              phase,
    input  logic                last,
    input  logic [CS_W-1:0]     l_cs,
    input  logic                l_wr,
    input  logic                l_ss,
    input  logic                l_wide,
    input  logic [ADDR_W-1:0]   l_addr,
    input  logic [15:0]         l_wdata,
    input  logic [15:0]         mem_din,
    output logic [NCS-1:0]      mem_cs_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic                mem_rw,
    output logic [ADDR_W-3:0]   mem_a,
    output logic [1:0]          mem_ba,
    output logic [15:0]         mem_dout,
    output logic                mem_doe,
    output logic [15:0]         rd_data,
    output logic                done,
    output logic                ready
);

    logic in_access;
    logic in_strobe;
    logic cs_on;
    logic capture;

    always_comb begin
        in_access = (phase == ST_SETUP) || (phase == ST_STROBE) || (phase == ST_HOLD);
        in_strobe = (phase == ST_STROBE);
        cs_on     = l_ss ? in_strobe : in_access;
        mem_oe_n  = !(in_strobe && !l_wr);
        mem_we_n  = !(in_strobe && l_wr);
        mem_rw    = !(in_access && l_wr);
        mem_doe   = in_access && l_wr;
        mem_dout  = lane_fmt(l_wide, l_wdata);
        mem_a     = l_addr[ADDR_W-1:2];
        mem_ba    = l_wide ? {l_addr[1], 1'b0} : l_addr[1:0];
        done      = (phase == ST_TURN) && last;
        ready     = (phase == ST_IDLE);
        capture   = in_strobe && last && !l_wr;
    end

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign mem_cs_n[g] = !(cs_on && (l_cs == CS_W'(g)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture) begin
            rd_data <= lane_fmt(l_wide, mem_din);
        end
    end

endmodule

// File: rtl/async_mem_seq.sv
module async_mem_seq
    import amseq_pkg::*;
#(
    parameter int NCS      = 4,
    parameter int ADDR_W   = 24,
    parameter int SETUP_W  = 4,
    parameter int STROBE_W = 6,
    parameter int HOLD_W   = 3,
    parameter int TURN_W   = 2,
    localparam int CS_W    = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [CS_W-1:0]          req_cs,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [15:0]              req_wdata,
    output logic                     req_ready,
    input  logic [NCS-1:0]           cfg_ss,
    input  logic [NCS-1:0]           cfg_wide,
    input  logic [NCS*SETUP_W-1:0]   cfg_rd_setup,
    input  logic [NCS*STROBE_W-1:0]  cfg_rd_strobe,
    input  logic [NCS*HOLD_W-1:0]    cfg_rd_hold,
    input  logic [NCS*SETUP_W-1:0]   cfg_wr_setup,
    input  logic [NCS*STROBE_W-1:0]  cfg_wr_strobe,
    input  logic [NCS*HOLD_W-1:0]    cfg_wr_hold,
    input  logic [NCS*TURN_W-1:0]    cfg_turn,
    output logic [NCS-1:0]           mem_cs_n,
    output logic                     mem_oe_n,
    output logic                     mem_we_n,
    output logic                     mem_rw,
    output logic [ADDR_W-3:0]        mem_a,
    output logic [1:0]               mem_ba,
    output logic [15:0]              mem_dout,
    output logic                     mem_doe,
    input  logic [15:0]              mem_din,
    output logic [15:0]              rd_data,
    output logic                     done
);

    logic [SETUP_W-1:0]  sel_setup;
    logic [STROBE_W-1:0] sel_strobe;
    logic [HOLD_W-1:0]   sel_hold;
    logic [TURN_W-1:0]   sel_turn;
    logic                sel_ss, sel_wide;

    logic [CS_W-1:0]     l_cs;
    logic                l_wr, l_ss, l_wide;
    logic [ADDR_W-1:0]   l_addr;
    logic [15:0]         l_wdata;
    logic [STROBE_W-1:0] l_strobe;
    logic [HOLD_W-1:0]   l_hold;
    logic [TURN_W-1:0]   l_turn;

    phase_e phase;
    logic   last;
    logic   start;

    amseq_cfg_sel #(
        .NCS(NCS), .CS_W(CS_W), .SETUP_W(SETUP_W),
        .STROBE_W(STROBE_W), .HOLD_W(HOLD_W), .TURN_W(TURN_W)
    ) u_cfg (
        .sel(req_cs), .write(req_write),
        .cfg_ss(cfg_ss), .cfg_wide(cfg_wide),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
        .cfg_turn(cfg_turn),
        .setup_len(sel_setup), .strobe_len(sel_strobe), .hold_len(sel_hold),
        .turn_len(sel_turn), .ss_mode(sel_ss), .wide(sel_wide)
    );

    assign start = req_valid && req_ready;

    // Capture the whole access description at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_cs     <= '0;
            l_wr     <= 1'b0;
            l_ss     <= 1'b0;
            l_wide   <= 1'b0;
            l_addr   <= '0;
            l_wdata  <= '0;
            l_strobe <= '0;
            l_hold   <= '0;
            l_turn   <= '0;
        end else if (start) begin
            l_cs     <= req_cs;
            l_wr     <= req_write;
            l_ss     <= sel_ss;
            l_wide   <= sel_wide;
            l_addr   <= req_addr;
            l_wdata  <= req_wdata;
            l_strobe <= sel_strobe;
            l_hold   <= sel_hold;
            l_turn   <= sel_turn;
        end
    end

    amseq_fsm #(
        .SETUP_W(SETUP_W), .STROBE_W(STROBE_W), .HOLD_W(HOLD_W), .TURN_W(TURN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .setup_len(sel_setup), .strobe_len(l_strobe),
        .hold_len(l_hold), .turn_len(l_turn),
        .phase(phase), .last(last)
    );

    amseq_pins #(
        .NCS(NCS), .CS_W(CS_W), .ADDR_W(ADDR_W)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .phase(phase), .last(last),
        .l_cs(l_cs), .l_wr(l_wr), .l_ss(l_ss), .l_wide(l_wide),
        .l_addr(l_addr), .l_wdata(l_wdata), .mem_din(mem_din),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_rw(mem_rw), .mem_a(mem_a), .mem_ba(mem_ba),
        .mem_dout(mem_dout), .mem_doe(mem_doe), .rd_data(rd_data),
        .done(done), .ready(req_ready)
    );

endmodule

// File: rtl/amseq_chk.sv
module amseq_chk #(
    parameter int NCS    = 4,
    parameter int ADDR_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               done,
    input logic [NCS-1:0]     mem_cs_n,
    input logic               mem_oe_n,
    input logic               mem_we_n,
    input logic               mem_rw,
    input logic [ADDR_W-3:0]  mem_a,
    input logic [1:0]         mem_ba,
    input logic               mem_doe
);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R2: idle bus is fully quiet
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_cs_n) && mem_oe_n && mem_we_n && mem_rw && !mem_doe);

    // R3: never more than one chip select low
    a_r3_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R5: a strobe is only ever given with a chip select low
    a_r5_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

    // R5: read and write strobes never overlap
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R6: write direction only while busy
    a_r6_rw_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rw |-> !req_ready);

    // R8: data driven only in write direction
    a_r8_doe_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> !mem_rw);

    // R7: address pins stay put through a busy stretch
    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !req_ready && !$past(req_ready)) |-> ($stable(mem_a) && $stable(mem_ba)));

    // R10: done is one cycle and is followed by idle
    a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));

endmodule

bind async_mem_seq amseq_chk #(.NCS(NCS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_rw(mem_rw), .mem_a(mem_a), .mem_ba(mem_ba), .mem_doe(mem_doe)
);

// File: tb/async_mem_seq_tb.sv
`timescale 1ns/1ps
module async_mem_seq_tb;

    localparam int NCS = 4, AW = 24, SW = 4, TW = 6, HW = 3, XW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic req_valid = 0, req_write = 0;
    logic [1:0] req_cs = 0;
    logic [AW-1:0] req_addr = 0;
    logic [15:0] req_wdata = 0, mem_din = 0;
    logic req_ready, mem_oe_n, mem_we_n, mem_rw, mem_doe, done;
    logic [NCS-1:0] mem_cs_n, cfg_ss, cfg_wide;
    logic [AW-3:0] mem_a;
    logic [1:0] mem_ba;
    logic [15:0] mem_dout, rd_data;
    logic [NCS*SW-1:0] f_rs, f_ws;
    logic [NCS*TW-1:0] f_rt, f_wt;
    logic [NCS*HW-1:0] f_rh, f_wh;
    logic [NCS*XW-1:0] f_ta;

    int c_rs[NCS], c_rt[NCS], c_rh[NCS], c_ws[NCS], c_wt[NCS], c_wh[NCS], c_ta[NCS];
    bit c_ss[NCS], c_wide[NCS];

    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            f_rs[i*SW +: SW] = SW'(c_rs[i]);  f_ws[i*SW +: SW] = SW'(c_ws[i]);
            f_rt[i*TW +: TW] = TW'(c_rt[i]);  f_wt[i*TW +: TW] = TW'(c_wt[i]);
            f_rh[i*HW +: HW] = HW'(c_rh[i]);  f_wh[i*HW +: HW] = HW'(c_wh[i]);
            f_ta[i*XW +: XW] = XW'(c_ta[i]);
            cfg_ss[i] = c_ss[i];  cfg_wide[i] = c_wide[i];
        end
    end

    async_mem_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .cfg_ss(cfg_ss), .cfg_wide(cfg_wide),
        .cfg_rd_setup(f_rs), .cfg_rd_strobe(f_rt), .cfg_rd_hold(f_rh),
        .cfg_wr_setup(f_ws), .cfg_wr_strobe(f_wt), .cfg_wr_hold(f_wh), .cfg_turn(f_ta),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_rw(mem_rw),
        .mem_a(mem_a), .mem_ba(mem_ba), .mem_dout(mem_dout), .mem_doe(mem_doe),
        .mem_din(mem_din), .rd_data(rd_data), .done(done)
    );

    int tests = 0, fails = 0;

    // Reference model: queue of expected phases (0 idle,1 setup,2 strobe,3 hold,4 turn)
    int q[$];
    int t_cs = 0;
    bit t_wr = 0, t_ss = 0, t_wide = 0;
    logic [AW-1:0] t_addr = 0;
    logic [15:0] t_wdata = 0, t_din = 0, e_rdata = 0;

    function automatic logic [15:0] fmt(bit w, logic [15:0] v);
        return w ? v : {8'h00, v[7:0]};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int ph;
        bit act, dn;
        logic [NCS-1:0] e_cs;
        ph = (q.size() > 0) ? q.pop_front() : 0;
        dn = (ph == 4) && (q.size() == 0);
        act = (ph >= 1) && (ph <= 3);
        e_cs = '1;
        if (t_ss ? (ph == 2) : act) e_cs[t_cs] = 1'b0;
        chk(req_ready == (ph == 0), "R2 req_ready", 32'(req_ready), 32'(ph == 0));
        chk(mem_cs_n == e_cs, t_ss ? "R4 cs_n strobe-only" : "R3 cs_n framed", 32'(mem_cs_n), 32'(e_cs));
        chk(mem_oe_n == !(ph == 2 && !t_wr), "R5 oe_n", 32'(mem_oe_n), 32'(!(ph == 2 && !t_wr)));
        chk(mem_we_n == !(ph == 2 && t_wr), "R5 we_n", 32'(mem_we_n), 32'(!(ph == 2 && t_wr)));
        chk(mem_rw == !(act && t_wr), "R6 rw", 32'(mem_rw), 32'(!(act && t_wr)));
        chk(mem_a == t_addr[AW-1:2], "R7 mem_a", 32'(mem_a), 32'(t_addr[AW-1:2]));
        chk(mem_ba == (t_wide ? {t_addr[1], 1'b0} : t_addr[1:0]), "R7 mem_ba",
            32'(mem_ba), 32'(t_wide ? {t_addr[1], 1'b0} : t_addr[1:0]));
        chk(mem_doe == (act && t_wr), "R8 doe", 32'(mem_doe), 32'(act && t_wr));
        if (act && t_wr)
            chk(mem_dout == fmt(t_wide, t_wdata), "R8 dout", 32'(mem_dout), 32'(fmt(t_wide, t_wdata)));
        chk(rd_data == e_rdata, "R9 rd_data", 32'(rd_data), 32'(e_rdata));
        chk(done == dn, "R10 done", 32'(done), 32'(dn));
        if (ph == 2 && q.size() > 0 && q[0] != 2 && !t_wr) e_rdata = fmt(t_wide, t_din);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    // Issue a request while idle, then run it to completion.
    // poke: mid-access stray request and configuration change (R2, R11)
    task automatic access(int cs, bit wr, logic [AW-1:0] addr, logic [15:0] wd,
                          logic [15:0] din, bit poke);
        int s, t, h, a;
        req_valid = 1; req_write = wr; req_cs = 2'(cs); req_addr = addr; req_wdata = wd;
        mem_din = din;
        t_cs = cs; t_wr = wr; t_ss = c_ss[cs]; t_wide = c_wide[cs];
        t_addr = addr; t_wdata = wd; t_din = din;
        s = wr ? c_ws[cs] : c_rs[cs];
        t = wr ? c_wt[cs] : c_rt[cs];
        h = wr ? c_wh[cs] : c_rh[cs];
        a = c_ta[cs];
        // R1: F+1 cycles per phase
        for (int i = 0; i <= s; i++) q.push_back(1);
        for (int i = 0; i <= t; i++) q.push_back(2);
        for (int i = 0; i <= h; i++) q.push_back(3);
        for (int i = 0; i <= a; i++) q.push_back(4);
        tick();
        req_valid = 0;
        for (int k = 0; q.size() > 0; k++) begin
            if (poke && k == 1) begin
                req_valid = 1; req_write = !wr; req_cs = 2'(cs ^ 1); req_addr = ~addr;
                c_ss[cs] = !c_ss[cs]; c_wide[cs] = !c_wide[cs];
                c_wt[cs] = 9; c_wh[cs] = 0; c_ta[cs] = 3;
            end
            if (poke && k == 3) req_valid = 0;
            tick();
        end
        tick();
    endtask

    initial begin
        for (int i = 0; i < NCS; i++) begin
            c_rs[i] = 0; c_rt[i] = 0; c_rh[i] = 0; c_ws[i] = 0; c_wt[i] = 0;
            c_wh[i] = 0; c_ta[i] = 0; c_ss[i] = 0; c_wide[i] = 1;
        end
        repeat (3) @(negedge clk);
        // R2: reset state observed while reset held
        chk(req_ready == 1 && mem_cs_n == '1 && rd_data == 0, "R2 reset", 32'(mem_cs_n), 32'hF);
        rst_n = 1;
        tick(); tick();

        // R1 R3 R8: 16-bit normal write, setup 2, strobe 3, hold 1, turn 2
        c_ws[1] = 1; c_wt[1] = 2; c_wh[1] = 0; c_ta[1] = 1;
        access(1, 1, 24'h00A5A6, 16'hBEEF, 16'h0000, 0);

        // R1 R5 R9: 16-bit normal read, all single-cycle phases, odd word
        access(0, 0, 24'h000003, 16'h0000, 16'h1234, 0);

        // R4 R7 R9: 8-bit select-strobe read, low address bits 11
        c_ss[2] = 1; c_wide[2] = 0;
        c_rs[2] = 2; c_rt[2] = 3; c_rh[2] = 1; c_ta[2] = 0;
        access(2, 0, 24'hFFFFF7, 16'h0000, 16'hAB5C, 0);

        // R2 R4 R8 R11: 8-bit select-strobe write with stray request and config change
        c_ss[3] = 1; c_wide[3] = 0;
        c_ws[3] = 2; c_wt[3] = 1; c_wh[3] = 2; c_ta[3] = 1;
        access(3, 1, 24'h400001, 16'hCAFE, 16'h0000, 1);

        // R11: the changed config now applies to the next access on that space
        access(3, 0, 24'h000102, 16'h0000, 16'h77EE, 0);

        // R1 R9: maximum read fields
        c_rs[1] = 15; c_rt[1] = 63; c_rh[1] = 7; c_ta[1] = 3;
        access(1, 0, 24'h123456, 16'h0000, 16'h0F0F, 0);

        // R9 R10: write after read leaves captured data alone; back-to-back
        access(0, 1, 24'h000010, 16'h5555, 16'hFFFF, 0);
        access(0, 0, 24'h000012, 16'h0000, 16'h9999, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule